// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a shared two-port memory and watches the enable, write strobe and address of both access ports on every clock. When both ports are enabled on the same address in the same cycle, it settles which port keeps the location and suppresses the other port's write strobe before it reaches the array. The result also goes out on a per-port busy flag, registered so that it is stable for a full cycle. Reads are never blocked.

A mode input selects the role. In master mode the block decides the winner itself. The earlier arrival wins. A true tie goes to a fixed, parameterised side. The winner is kept for as long as both ports stay on the contested address. In slave mode the block makes no decision of its own and holds its busy outputs low. It takes busy flags from a master device instead, so several devices can share one arbitration result when they are cascaded for a wider word. Because a master's flags appear one clock after the match, a slave holds back both writes during the first cycle of any match.

Top module: `dpa_busy_arbiter`

## Requirements
- R1: When the two ports are not both enabled on one address, in master mode each write-strobe output equals its port's enable AND write input, and in the next cycle both busy outputs are 0.
- R2: In master mode, if one port was already enabled on the address in the previous cycle and the other port has just arrived on it, the port that was already there wins and the arriving port loses.
- R3: In master mode, if both ports arrive on a shared address in the same cycle, exactly one of them wins. With the default TIE_LEFT=1 the left port wins; with TIE_LEFT=0 the right port wins.
- R4: While both ports stay enabled on the contested address from one cycle to the next, the winner does not change.
- R5: A busy output is 1 in the cycle after a master-mode cycle in which that port lost a collision, and is 0 in the cycle after that condition ends.
- R6: In master mode, the losing port's write-strobe output is 0 in the collision cycle itself, and the winning port's write-strobe output equals its enable AND write input.
- R7: In slave mode, both busy outputs are 0 in the following cycle. The local decision has no effect, and a port's write-strobe output is 0 whenever its busy input is 1.
- R8: In slave mode, in the first cycle of a collision (no collision in the previous cycle), both write-strobe outputs are 0. In later collision cycles each port's write-strobe output is its enable AND write AND NOT busy input.
- R9: After reset, both busy outputs are 0, and a port enabled in the first active cycle counts as newly arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slave_mode | input | 1 | 1 = take busy from inputs, 0 = arbitrate locally |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in | input | 1 | Busy flag for left port from a master (slave mode) |
| r_busy_in | input | 1 | Busy flag for right port from a master (slave mode) |
| l_busy_out | output | 1 | Registered busy flag for left port (master mode) |
| r_busy_out | output | 1 | Registered busy flag for right port (master mode) |
| l_we_ok | output | 1 | Gated left write strobe to the array |
| r_we_ok | output | 1 | Gated right write strobe to the array |

## Verification
The in-RTL assertions check on every cycle the properties that hold at a single point in time. A master-mode collision yields exactly one loser, and an established port beats a newcomer. A loser's strobe is dropped. Slave mode keeps the busy outputs low and blocks the first collision cycle. Busy clears one cycle after a collision ends. Other behaviours depend on a history of several cycles: the winner held across a long collision, re-arbitration after one port moves to another address, the tie side, and the reset rule that a port counts as newly arrived. Only the bench's sweeps over every two-cycle pattern of enables and addresses, in both modes, can show these against its own cycle model.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {WIN_L = 1'b0, WIN_R = 1'b1} win_e;
  localparam int NPORTS = 2;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              stay
);
  logic              en_q, en_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_ce;

  assign addr_ce = en;

  always_comb begin
    en_d   = en;
    addr_d = addr_q;
    if (addr_ce) addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_d;
      addr_q <= addr_d;
    end
  end

  assign stay = en & en_q & (addr == addr_q);
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic collide,
  input  logic l_stay,
  input  logic r_stay,
  output win_e win,
  output logic coll_q
);
  localparam win_e TIE_WIN = TIE_LEFT ? WIN_L : WIN_R;

  win_e win_q;
  logic held;

  assign held = coll_q & l_stay & r_stay;

  always_comb begin
    if (held)                 win = win_q;
    else if (l_stay & !r_stay) win = WIN_L;
    else if (r_stay & !l_stay) win = WIN_R;
    else                       win = TIE_WIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= WIN_L;
      coll_q <= 1'b0;
    end else begin
      win_q  <= win;
      coll_q <= collide;
    end
  end

  assert_earlier_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && l_stay && !r_stay) |-> (win == WIN_L));
  assert_earlier_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && r_stay && !l_stay) |-> (win == WIN_R));
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
  input  logic slave_mode,
  input  logic en,
  input  logic we,
  input  logic lose_now,
  input  logic busy_in,
  input  logic first_coll,
  output logic we_ok
);
  logic req;
  logic block;

  assign req = en & we;

  always_comb begin
    if (slave_mode) block = busy_in | first_coll;
    else            block = lose_now;
  end

  assign we_ok = req & ~block;
endmodule

// File: rtl/dpa_busy_arbiter.sv
module dpa_busy_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in,
  input  logic              r_busy_in,
  output logic              l_busy_out,
  output logic              r_busy_out,
  output logic              l_we_ok,
  output logic              r_we_ok
);
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic              en_v   [NPORTS];
  logic              we_v   [NPORTS];
  logic [ADDR_W-1:0] addr_v [NPORTS];
  logic              bin_v  [NPORTS];
  logic              stay_v [NPORTS];
  logic              lose_v [NPORTS];
  logic              ok_v   [NPORTS];

  assign en_v[0] = l_en;  assign en_v[1] = r_en;
  assign we_v[0] = l_we;  assign we_v[1] = r_we;
  assign addr_v[0] = l_addr; assign addr_v[1] = r_addr;
  assign bin_v[0] = l_busy_in; assign bin_v[1] = r_busy_in;

  logic collide, coll_q, first_coll;
  win_e win;

  assign collide    = l_en & r_en & (l_addr == r_addr);
  assign first_coll = collide & ~coll_q;

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
        .clk  (clk),
        .rst_n(rst_i_n),
        .en   (en_v[p]),
        .addr (addr_v[p]),
        .stay (stay_v[p])
      );
      dpa_write_gate u_gate (
        .slave_mode(slave_mode),
        .en        (en_v[p]),
        .we        (we_v[p]),
        .lose_now  (lose_v[p]),
        .busy_in   (bin_v[p]),
        .first_coll(first_coll),
        .we_ok     (ok_v[p])
      );
    end
  endgenerate

  dpa_arbiter #(.TIE_LEFT(TIE_LEFT)) u_arb (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .collide(collide),
    .l_stay (stay_v[0]),
    .r_stay (stay_v[1]),
    .win    (win),
    .coll_q (coll_q)
  );

  assign lose_v[0] = collide & (win == WIN_R);
  assign lose_v[1] = collide & (win == WIN_L);

  logic busy_l_q, busy_r_q, busy_l_d, busy_r_d, busy_ce;

  assign busy_ce = 1'b1;

  always_comb begin
    busy_l_d = busy_l_q;
    busy_r_d = busy_r_q;
    if (busy_ce) begin
      busy_l_d = ~slave_mode & lose_v[0];
      busy_r_d = ~slave_mode & lose_v[1];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_l_q <= 1'b0;
      busy_r_q <= 1'b0;
    end else begin
      busy_l_q <= busy_l_d;
      busy_r_q <= busy_r_d;
    end
  end

  assign l_busy_out = busy_l_q;
  assign r_busy_out = busy_r_q;
  assign l_we_ok    = ok_v[0];
  assign r_we_ok    = ok_v[1];

  assert_one_loser_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (collide && !slave_mode) |-> ($countones({lose_v[0], lose_v[1]}) == 1));
  assert_busy_clears_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !collide |=> (!l_busy_out && !r_busy_out));
  assert_loser_blocked_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!slave_mode && collide) |-> !(l_we_ok && r_we_ok));
  assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    slave_mode |=> (!l_busy_out && !r_busy_out));
  assert_slave_first_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (slave_mode && collide && !coll_q) |-> (!l_we_ok && !r_we_ok));
endmodule

// File: tb/dpa_busy_arbiter_tb.sv
module dpa_busy_arbiter_tb;
  localparam int AW = 13;
  localparam bit TIE = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic l_en = 1'b0, l_we = 1'b0, r_en = 1'b0, r_we = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in = 1'b0, r_busy_in = 1'b0;
  logic l_busy_out, r_busy_out, l_we_ok, r_we_ok;

  int checks = 0;
  int errors = 0;

  // model state
  logic p_len = 0, p_ren = 0, p_coll = 0, p_lw = 1, p_bl = 0, p_br = 0;
  logic [AW-1:0] p_la = '0, p_ra = '0;

  always #2 clk = ~clk;

  dpa_busy_arbiter #(.ADDR_W(AW), .TIE_LEFT(TIE)) u_dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_we_ok(l_we_ok), .r_we_ok(r_we_ok)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check, advance model at posedge
  task automatic step(input logic sl, input logic len, input logic lwe, input int la,
                      input logic ren, input logic rwe, input int ra,
                      input logic bil, input logic bir);
    logic coll, lst, rst, lw, el, er;
    @(negedge clk);
    slave_mode = sl; l_en = len; l_we = lwe; l_addr = AW'(la);
    r_en = ren; r_we = rwe; r_addr = AW'(ra);
    l_busy_in = bil; r_busy_in = bir;
    #1;
    coll = len & ren & (la == ra);
    lst = len & p_len & (AW'(la) == p_la);
    rst = ren & p_ren & (AW'(ra) == p_ra);
    if (coll & p_coll & lst & rst) lw = p_lw;
    else if (lst & !rst) lw = 1'b1;
    else if (rst & !lst) lw = 1'b0;
    else lw = TIE;
    chk("R5 l_busy_out", l_busy_out, p_bl);
    chk("R5 r_busy_out", r_busy_out, p_br);
    if (sl) begin
      el = len & lwe & !bil & !(coll & !p_coll);
      er = ren & rwe & !bir & !(coll & !p_coll);
      chk("R8 l_we_ok", l_we_ok, el);
      chk("R8 r_we_ok", r_we_ok, er);
    end else begin
      el = len & lwe & !(coll & !lw);
      er = ren & rwe & !(coll & lw);
      chk("R6 l_we_ok", l_we_ok, el);
      chk("R6 r_we_ok", r_we_ok, er);
    end
    @(posedge clk);
    p_bl = !sl & coll & !lw;
    p_br = !sl & coll & lw;
    p_coll = coll; p_lw = lw;
    p_len = len; p_ren = ren;
    if (len) p_la = AW'(la);
    if (ren) p_ra = AW'(ra);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset l_busy_out", l_busy_out, 1'b0);
    chk("R9 reset r_busy_out", r_busy_out, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R9: both enabled on same address in first active cycle -> tie rule
    step(0, 1, 1, 5, 1, 1, 5, 0, 0);
    chk("R9 R3 tie gives left", l_we_ok, 1'b1);
    // R4: hold
    step(0, 1, 1, 5, 1, 1, 5, 0, 0);
    chk("R4 r_busy_out held", r_busy_out, 1'b1);
    step(0, 1, 1, 5, 1, 1, 5, 0, 0);
    chk("R4 right still blocked", r_we_ok, 1'b0);
    // R5: end collision
    step(0, 1, 1, 5, 1, 1, 6, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 busy cleared", r_busy_out, 1'b0);
    chk("R1 idle no busy", l_busy_out, 1'b0);
    // R2: right first, left arrives -> right wins
    step(0, 0, 0, 0, 1, 1, 9, 0, 0);
    step(0, 1, 1, 9, 1, 1, 9, 0, 0);
    chk("R2 late left blocked", l_we_ok, 1'b0);
    chk("R2 early right passes", r_we_ok, 1'b1);
    step(0, 1, 1, 9, 1, 1, 9, 0, 0);
    chk("R2 R5 l_busy_out", l_busy_out, 1'b1);
    // R7: slave ignores local, uses busy_in
    step(1, 1, 1, 3, 1, 1, 3, 0, 1);
    step(1, 1, 1, 3, 1, 1, 3, 0, 1);
    chk("R7 slave busy out low", l_busy_out | r_busy_out, 1'b0);
    chk("R7 left passes by busy_in", l_we_ok, 1'b1);
    chk("R7 right blocked by busy_in", r_we_ok, 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // sweeps over all two-cycle patterns in both modes
    for (int sl = 0; sl < 2; sl++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          step(sl[0], a[0], 1'b1, (a >> 2) & 1, a[1], 1'b1, (a >> 3) & 1,
               a[0] ^ b[1], b[0]);
          step(sl[0], b[0], 1'b1, (b >> 2) & 1, b[1], b[2] ^ a[3], (b >> 3) & 1,
               b[3], a[1] ^ b[2]);
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule